// File: doc/BRIEF.md
# Down-Counting Raster Timing Generator

This block produces the horizontal and vertical sync, blank and active-video strobes for a display controller. Two down-counters sweep the raster. The horizontal counter starts at a programmed total, loses one each pixel clock and reloads after it reaches zero. The vertical counter moves one line each time the horizontal counter wraps. Each of the six strobes is decoded against its own window register. A window register holds a start count in its low half and a stop count in its high half. The strobe is high while the falling count is at or below the start and still above the stop.

The timing registers sit on a small register bus. The bus has a select, a write flag, a 12-bit byte offset and 32-bit data. All timing registers are protected. A write of the key 0xAA to the lock offset opens them for the next bus access only. Software therefore issues the key and then the write, as a pair, with no wait between them. For a mode that has active width W, leading margin L, trailing margin T and sync length S, software sets these values:
- total = W+L+T+S-1
- sync window: start = total, stop = total-S
- blank and active windows: start = total-S-L, stop = T-1

Top module: `raster_sweep_gen`

## Requirements
- R1: After reset every register reads zero, the block is locked, both counters are zero and all six strobes are low.
- R2: A write of 0xAA to offset 0x07C opens the protected registers for the next access only. A read of offset 0x07C returns 1 in bit 0 when the block is open at that read, and 0 otherwise.
- R3: A write to a protected register while the block is locked leaves the register unchanged.
- R4: Any access other than the key write locks the block again. This includes a read or a write to an unmapped offset, so a protected write that follows such an access is ignored.
- R5: The registers read back their full 32 bits in the cycle after the read access. The offsets are 0x010 horizontal total, 0x014 horizontal sync, 0x018 horizontal active, 0x22C horizontal blank, 0x000 vertical total, 0x004 vertical sync, 0x008 vertical active, 0x228 vertical blank and 0x024 control. An unmapped offset reads zero.
- R6: While control bit 0 (enable) is clear, each counter is loaded with its total on every clock and all six strobes are low.
- R7: While the block is enabled, the horizontal counter shows its total in the cycle after enable is set. It then falls by one each clock and reloads the total on the clock after it shows zero.
- R8: The vertical counter changes only on a clock where the horizontal counter shows zero. On that clock it falls by one, or it reloads its total when it also shows zero, so both counters wrap together at the end of a frame.
- R9: Each strobe is high exactly when its counter is at or below bits 15:0 of its window register and above bits 31:16, and only while the block is enabled.
- R10: A write of any value other than 0xAA to the lock offset does not open the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| h_sync | output | 1 | Horizontal sync strobe |
| h_blank | output | 1 | Horizontal blank strobe |
| h_active | output | 1 | Horizontal active-video strobe |
| v_sync | output | 1 | Vertical sync strobe |
| v_blank | output | 1 | Vertical blank strobe |
| v_active | output | 1 | Vertical active-video strobe |
| h_count | output | 16 | Current horizontal count |
| v_count | output | 16 | Current vertical count |

## Verification
At the last pixel of a frame two events fall on the same clock. The horizontal reload and the vertical reload both take place there, because the line step and the frame wrap come from the same zero count. The bench programs a raster of 15 clocks by 8 lines and lets it run for more than two frames. Each cycle it predicts both counters from the number of cycles since enable. It names a separate check at the clock where both counters show zero, and at the clock that follows, where both must show their totals again.

// File: rtl/raster_pkg.sv
// raster_pkg: shared widths, register identifiers, offsets and the address
// decoder for the raster timing generator.
// Assumes a 12-bit byte-offset bus and 32-bit registers.
package raster_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 9;
    localparam int NUM_WIN  = 6;
    localparam int HALF_W   = DATA_W / 2;

    localparam logic [ADDR_W-1:0] LOCK_OFF   = 12'h07C;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;
    localparam int                ENABLE_BIT = 0;

    typedef enum logic [3:0] {
        RG_VTOT  = 4'd0,
        RG_VSYNC = 4'd1,
        RG_VACT  = 4'd2,
        RG_VBLK  = 4'd3,
        RG_HTOT  = 4'd4,
        RG_HSYNC = 4'd5,
        RG_HACT  = 4'd6,
        RG_HBLK  = 4'd7,
        RG_CTRL  = 4'd8,
        RG_NONE  = 4'd15
    } reg_id_e;

    // Map a byte offset onto a protected register, or RG_NONE.
    function automatic reg_id_e decode_off(input logic [ADDR_W-1:0] off);
        case (off)
            12'h000: return RG_VTOT;
            12'h004: return RG_VSYNC;
            12'h008: return RG_VACT;
            12'h228: return RG_VBLK;
            12'h010: return RG_HTOT;
            12'h014: return RG_HSYNC;
            12'h018: return RG_HACT;
            12'h22C: return RG_HBLK;
            12'h024: return RG_CTRL;
            default: return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/raster_regfile.sv
// raster_regfile: holds the protected timing registers and the one-shot
// unlock flag, and serves bus reads with one cycle of latency.
// Assumes at most one access per cycle. The key write opens the block and
// every other access closes it.
module raster_regfile
    import raster_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic                            en_o,
    output logic [CNT_W-1:0]                htot_o,
    output logic [CNT_W-1:0]                vtot_o,
    output logic [NUM_WIN-1:0][DATA_W-1:0]  win_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic                            open_q;
    reg_id_e                         hit;
    logic                            key_wr;

    assign hit    = decode_off(bus_addr);
    assign key_wr = bus_sel && bus_wr && (bus_addr == LOCK_OFF) && (bus_wdata == UNLOCK_KEY);

    // One-shot unlock: set by the key write, cleared by any other access.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= 1'b0;
        else if (bus_sel) open_q <= key_wr;
    end

    // Protected register storage, written only while open.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (bus_sel && bus_wr && open_q && (hit == reg_id_e'(i)))
                regs_q[i] <= bus_wdata;
        end
    end

    // Registered read path: lock status, mapped register or zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_sel && !bus_wr) begin
            if (bus_addr == LOCK_OFF)
                bus_rdata <= {{(DATA_W-1){1'b0}}, open_q};
            else if (hit != RG_NONE)
                bus_rdata <= regs_q[hit[3:0]];
            else
                bus_rdata <= '0;
        end
    end

    assign en_o     = regs_q[RG_CTRL][ENABLE_BIT];
    assign htot_o   = regs_q[RG_HTOT][CNT_W-1:0];
    assign vtot_o   = regs_q[RG_VTOT][CNT_W-1:0];
    assign win_o[0] = regs_q[RG_HSYNC];
    assign win_o[1] = regs_q[RG_HBLK];
    assign win_o[2] = regs_q[RG_HACT];
    assign win_o[3] = regs_q[RG_VSYNC];
    assign win_o[4] = regs_q[RG_VBLK];
    assign win_o[5] = regs_q[RG_VACT];

    // R3: a locked write never changes storage.
    p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !open_q && hit != RG_NONE) |=> $stable(regs_q));
    // R2: the key write opens the block for the following access.
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> open_q);
    // R4: any other access leaves the block locked.
    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !key_wr) |=> !open_q);

    // Read data changes only in the cycle after a read access.
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

// File: rtl/raster_downcounter.sv
// raster_downcounter: a down-counter for one raster axis. It is held at the
// total while disabled. On each step it falls by one, or it reloads the total
// after zero. wrap_o flags a step taken at zero.
// Assumes total is stable while the counter runs.
module raster_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_o
);

    assign wrap_o = en && step && (cnt == '0);

    // Load while disabled, otherwise count down and reload after zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!en)      cnt <= total;
        else if (wrap_o)   cnt <= total;
        else if (step)     cnt <= cnt - 1'b1;
    end

    // R6: a disabled cycle leaves the counter at the total.
    p_hold_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == $past(total)));
    // R7: a step above zero lowers the count by exactly one.
    p_decrement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && cnt != '0) |=> (!en || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/raster_window.sv
// raster_window: decodes one strobe from a count and a packed window word
// (start in the low half, stop in the high half).
// Assumes CNT_W does not exceed half the register width.
module raster_window
    import raster_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] win,
    output logic              out
);

    logic [CNT_W-1:0] start_v;
    logic [CNT_W-1:0] stop_v;

    assign start_v = win[CNT_W-1:0];
    assign stop_v  = win[HALF_W+CNT_W-1:HALF_W];

    // Strobe is high inside (stop, start], gated by enable.
    always_comb out = en && (cnt <= start_v) && (cnt > stop_v);

endmodule

// File: rtl/raster_sweep_gen.sv
// raster_sweep_gen: the top level of the raster timing generator. It joins
// the protected register file, the two axis down-counters and six window
// decoders.
// Assumes CNT_W <= 16 and one bus access per cycle.
module raster_sweep_gen
    import raster_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              h_sync,
    output logic              h_blank,
    output logic              h_active,
    output logic              v_sync,
    output logic              v_blank,
    output logic              v_active,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count
);

    localparam int H_WINS = NUM_WIN / 2;

    logic                           en;
    logic [CNT_W-1:0]               htot, vtot;
    logic [NUM_WIN-1:0][DATA_W-1:0] win;
    logic [NUM_WIN-1:0]             strobe;
    logic                           h_wrap, v_wrap;

    raster_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_o(en), .htot_o(htot), .vtot_o(vtot), .win_o(win)
    );

    raster_downcounter #(.CNT_W(CNT_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .en(en), .step(1'b1),
        .total(htot), .cnt(h_count), .wrap_o(h_wrap)
    );

    raster_downcounter #(.CNT_W(CNT_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .en(en), .step(h_wrap),
        .total(vtot), .cnt(v_count), .wrap_o(v_wrap)
    );

    // Windows 0..2 follow the horizontal count, windows 3..5 the vertical.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        raster_window #(.CNT_W(CNT_W)) u_win (
            .en(en),
            .cnt((w < H_WINS) ? h_count : v_count),
            .win(win[w]),
            .out(strobe[w])
        );
    end

    assign h_sync   = strobe[0];
    assign h_blank  = strobe[1];
    assign h_active = strobe[2];
    assign v_sync   = strobe[3];
    assign v_blank  = strobe[4];
    assign v_active = strobe[5];

    // R8: the vertical count moves only on a horizontal zero.
    p_vstep_only_on_hzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && h_count != '0) |=> (!en || $stable(v_count)));
    // R8: a frame wrap reloads both counters together.
    p_frame_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_wrap && en) |=> (!en || (h_count == $past(htot) && v_count == $past(vtot))));

endmodule

// File: tb/raster_sweep_gen_tb.sv
`timescale 1ns/1ps
module raster_sweep_gen_tb_top;

    localparam int HTOT = 14;
    localparam int VTOT = 7;
    localparam int NVEC = 8;
    localparam int SWEEP = 260;

    // Programming vectors: {offset, value}; each is written and read back.
    localparam logic [43:0] VEC [NVEC] = '{
        {12'h010, 32'd14},
        {12'h014, 32'h000C_000E},
        {12'h22C, 32'h0002_000A},
        {12'h018, 32'h0002_000A},
        {12'h000, 32'd7},
        {12'h004, 32'h0006_0007},
        {12'h228, 32'h0001_0005},
        {12'h008, 32'h0001_0005}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        h_sync, h_blank, h_active, v_sync, v_blank, v_active;
    logic [15:0] h_count, v_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    raster_sweep_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .h_sync(h_sync), .h_blank(h_blank), .h_active(h_active),
        .v_sync(v_sync), .v_blank(v_blank), .v_active(v_active),
        .h_count(h_count), .v_count(v_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic unlocked_write(input logic [11:0] a, input logic [31:0] d);
        bus_write(12'h07C, 32'hAA);
        bus_write(a, d);
    endtask

    function automatic logic inwin(input int c, input logic [31:0] w);
        return (c <= int'(w[15:0])) && (c > int'(w[31:16]));
    endfunction

    initial begin
        logic [31:0] rd;
        int h, v;
        logic [5:0] exp_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 counters", {h_count, v_count}, 32'h0);
        check("R1 strobes", {h_sync, h_blank, h_active, v_sync, v_blank, v_active}, 6'b0);
        bus_read(12'h014, rd); check("R1 hsync reg", rd, 32'h0);
        bus_read(12'h07C, rd); check("R1 locked", rd, 32'h0);

        // R5: vector table, each entry unlocked, written and read back
        for (int i = 0; i < NVEC; i++) begin
            unlocked_write(VEC[i][43:32], VEC[i][31:0]);
            bus_read(VEC[i][43:32], rd);
            check("R5 readback", rd, VEC[i][31:0]);
        end
        bus_read(12'h3F0, rd); check("R5 unmapped reads zero", rd, 32'h0);

        // R3: locked write ignored
        bus_write(12'h014, 32'hDEAD_BEEF);
        bus_read(12'h014, rd); check("R3 locked write", rd, 32'h000C_000E);

        // R10: wrong key does not open
        bus_write(12'h07C, 32'h55);
        bus_write(12'h014, 32'h1111_2222);
        bus_read(12'h014, rd); check("R10 wrong key", rd, 32'h000C_000E);

        // R4: a read between key and write relocks
        bus_write(12'h07C, 32'hAA);
        bus_read(12'h010, rd);
        bus_write(12'h014, 32'h3333_4444);
        bus_read(12'h014, rd); check("R4 read relocks", rd, 32'h000C_000E);

        // R4: an unmapped write between key and write relocks
        bus_write(12'h07C, 32'hAA);
        bus_write(12'h3F0, 32'h1);
        bus_write(12'h014, 32'h5555_6666);
        bus_read(12'h014, rd); check("R4 unmapped write relocks", rd, 32'h000C_000E);

        // R2: open status visible to one read only
        bus_write(12'h07C, 32'hAA);
        bus_read(12'h07C, rd); check("R2 open seen", rd, 32'h1);
        bus_read(12'h07C, rd); check("R2 one access only", rd, 32'h0);

        // R6: disabled, counters held at totals, strobes low
        check("R6 held at totals", {h_count, v_count}, {16'd14, 16'd7});
        check("R6 strobes low", {h_sync, h_blank, h_active, v_sync, v_blank, v_active}, 6'b0);

        // Enable and sweep more than two frames (R7, R8, R9)
        unlocked_write(12'h024, 32'h1);
        for (int t = 0; t < SWEEP; t++) begin
            h = HTOT - (t % (HTOT + 1));
            v = VTOT - ((t / (HTOT + 1)) % (VTOT + 1));
            exp_s = {inwin(h, VEC[1][31:0]), inwin(h, VEC[2][31:0]), inwin(h, VEC[3][31:0]),
                     inwin(v, VEC[5][31:0]), inwin(v, VEC[6][31:0]), inwin(v, VEC[7][31:0])};
            check("R7 R8 counters", {h_count, v_count}, {16'(h), 16'(v)});
            check("R9 strobes", {h_sync, h_blank, h_active, v_sync, v_blank, v_active}, exp_s);
            if (t == 119) check("R8 both at zero", {h_count, v_count}, 32'h0);
            if (t == 120) check("R8 both reload", {h_count, v_count}, {16'd14, 16'd7});
            @(negedge clk);
        end

        // R6: disable; one decrement lands on the write edge, reload on the next
        unlocked_write(12'h024, 32'h0);
        @(negedge clk);
        check("R6 reload on disable", {h_count, v_count}, {16'd14, 16'd7});
        check("R6 strobes gated", {h_sync, h_blank, h_active, v_sync, v_blank, v_active}, 6'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule